// File: doc/BRIEF.md
# Configuration Ring with Parallel Holding Word

This block closes a chain of 64-bit configuration shift segments, one per cell of an XSIZE × YSIZE array, into a single ring. A 64-bit holding word sits inside that ring, between the last cell and the first. Each clock edge without a write moves the whole ring forward by one bit. A write edge instead loads the holding word in parallel from the write port, and nothing in the ring moves on that edge.

The holding word is always driven onto the parallel read port. To edit one cell, software rotates the ring until that cell's word sits in the holding word. It then reads the word, overwrites it, and keeps rotating until the edited word is back in its own cell. Because the holding word is one slot of the ring, a full lap is (XSIZE·YSIZE + 1) × 64 shift edges, and it returns every bit to its starting place. A bit leaves the holding word from its top bit into bit 0 of cell 0. It leaves each cell from bit 63 into the next cell. It leaves the last cell into bit 0 of the holding word.

Each edge is decoded into one of two named operations. OP_ROTATE is taken when the write strobe is low and shifts all slots. OP_LOAD is taken when the write strobe is high: it replaces the holding word and freezes the cells. Any edge can switch between the two. Reset overrides both.

Top module: `scan_ring`

## Requirements
- R1: A synchronous reset clears the holding word and every cell segment, so the read port shows zero and every word met during a following lap is zero.
- R2: On an edge with `wr_en` high, the holding word takes `wr_data`, and that value is on `rd_data` after the edge.
- R3: On an edge with `wr_en` high, no cell segment shifts: `ring_rx` keeps its value, and every other word of the ring is unchanged when it is next rotated into view.
- R4: On an edge with `wr_en` low, the holding word becomes {previous bits 62..0, previous `ring_rx`}.
- R5: After 64 consecutive shift edges starting from word alignment, the holding word holds the former content of the last cell, and each word has moved one slot along the ring (holding → cell 0 → … → last cell → holding).
- R6: After exactly (XSIZE·YSIZE + 1) × 64 shift edges, every word of the ring, including the holding word, is back at its original position.
- R7: `ring_tx` is bit 63 of the holding word, the bit that next enters cell 0. `ring_rx` is bit 63 of the last cell, the bit that next enters the holding word.
- R8: The ring holds exactly XSIZE·YSIZE cell words plus the holding word. A word written into the holding word is in the last cell after XSIZE·YSIZE × 64 shift edges, and the holding word then shows the word that preceded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the whole ring |
| wr_en | input | 1 | Load strobe; high loads the holding word and stops the ring for that edge |
| wr_data | input | 64 | Parallel value for the holding word |
| rd_data | output | 64 | Current holding word |
| ring_tx | output | 1 | Serial bit leaving the holding word toward cell 0 |
| ring_rx | output | 1 | Serial bit leaving the last cell toward the holding word |

## Verification
Every result is one register stage deep. A load or a single shift shows on `rd_data`, `ring_tx` and `ring_rx` after the very next rising edge. A word moves one slot after 64 shift edges, and a lap is complete after (cells + 1) × 64 edges. The bench drives its inputs at the falling edge and samples on the next falling edge, after the single register update. Word positions are checked only at multiples of 64 shift edges, against a word-level ring model that rotates once per 64 edges. Frozen cells and full-lap restoration are shown by rotating each word back into the holding word and comparing it there.

// File: rtl/scan_ring_pkg.sv
package scan_ring_pkg;

    localparam int unsigned WORD_W = 64;

    typedef logic [WORD_W-1:0] word_t;

    // Operation applied to the ring on a clock edge
    typedef enum logic [0:0] {
        OP_ROTATE = 1'b0,
        OP_LOAD   = 1'b1
    } ring_op_e;

endpackage

// File: rtl/scan_cell_seg.sv
module scan_cell_seg
    import scan_ring_pkg::*;
#(
    parameter int unsigned SEG_W = WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic ser_in,
    output logic ser_out
);

    logic [SEG_W-1:0] seg_q;

    // Bit 0 takes the incoming serial bit; bit SEG_W-1 feeds the next slot
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
        end else if (shift_en) begin
            seg_q <= {seg_q[SEG_W-2:0], ser_in};
        end
    end

    assign ser_out = seg_q[SEG_W-1];

endmodule

// File: rtl/scan_hold_word.sv
module scan_hold_word
    import scan_ring_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ring_op_e op,
    input  word_t    load_val,
    input  logic     ser_in,
    output word_t    word_q,
    output logic     ser_out
);

    word_t word_d;

    always_comb begin
        word_d = word_q;
        unique case (op)
            OP_ROTATE: word_d = {word_q[WORD_W-2:0], ser_in};
            OP_LOAD:   word_d = load_val;
            default:   word_d = word_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign ser_out = word_q[WORD_W-1];

endmodule

// File: rtl/scan_ring.sv
module scan_ring
    import scan_ring_pkg::*;
#(
    parameter int unsigned XSIZE = 20,
    parameter int unsigned YSIZE = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data,
    output logic        ring_tx,
    output logic        ring_rx
);

    localparam int unsigned NCELL = XSIZE * YSIZE;

    ring_op_e op;
    logic     cell_shift;
    word_t    hold_q;
    logic     hold_out;

    // link[k] is the serial input of cell k; link[NCELL] closes the ring
    logic [NCELL:0] link;

    always_comb begin
        op         = wr_en ? OP_LOAD : OP_ROTATE;
        cell_shift = 1'b0;
        unique case (op)
            OP_ROTATE: cell_shift = 1'b1;
            OP_LOAD:   cell_shift = 1'b0;
            default:   cell_shift = 1'b0;
        endcase
    end

    scan_hold_word u_hold (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (wr_data),
        .ser_in   (link[NCELL]),
        .word_q   (hold_q),
        .ser_out  (hold_out)
    );

    assign link[0] = hold_out;

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        scan_cell_seg #(.SEG_W(WORD_W)) u_seg (
            .clk      (clk),
            .rst      (rst),
            .shift_en (cell_shift),
            .ser_in   (link[k]),
            .ser_out  (link[k+1])
        );
    end

    assign rd_data = hold_q;
    assign ring_tx = hold_out;
    assign ring_rx = link[NCELL];

endmodule

// File: rtl/scan_ring_chk.sv
module scan_ring_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic [63:0] rd_data,
    input logic        ring_tx,
    input logic        ring_rx
);

    // R1: the first edge after reset release still sees a cleared ring
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data == 64'd0 && ring_rx == 1'b0 && ring_tx == 1'b0));

    // R2: a load edge puts the write data on the read port
    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data)));

    // R3: cells are frozen on a load edge
    p_cells_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(ring_rx));

    // R4: a shift edge moves the ring by one bit into the holding word
    p_shift_in_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_data == {$past(rd_data[62:0]), $past(ring_rx)}));

    // R7: the outgoing serial bit walks up the holding word
    p_tx_order_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (ring_tx == $past(rd_data[62])));

endmodule

bind scan_ring scan_ring_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ring_tx (ring_tx),
    .ring_rx (ring_rx)
);

// File: tb/scan_ring_test.sv
module scan_ring_test;

    localparam int XS = 3;
    localparam int YS = 2;
    localparam int NC = XS * YS;
    localparam int NW = NC + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        ring_tx;
    logic        ring_rx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Word model: slot 0 = holding word, slot k = cell k-1
    logic [63:0] mdl  [NW];
    logic [63:0] snap [NW];

    always #4 clk = ~clk;

    scan_ring #(.XSIZE(XS), .YSIZE(YS)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ring_tx (ring_tx),
        .ring_rx (ring_rx)
    );

    task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic we, logic [63:0] d);
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rotate_word();
        logic [63:0] t;
        for (int i = 0; i < 64; i++) step(1'b0, '0);
        t = mdl[NW-1];
        for (int k = NW - 1; k > 0; k--) mdl[k] = mdl[k-1];
        mdl[0] = t;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NW; k++) mdl[k] = '0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk64("R1 rd_data after reset", rd_data, '0);
        chk64("R1 ring_rx after reset", {63'd0, ring_rx}, '0);
        for (int w = 0; w < NW; w++) begin
            rotate_word();
            chk64("R1 word in lap after reset", rd_data, '0);
        end
    endtask

    task automatic t_load();
        logic rx0;
        rx0 = ring_rx;
        step(1'b1, 64'h8123_4567_89AB_CDEF);
        mdl[0] = 64'h8123_4567_89AB_CDEF;
        chk64("R2 load value", rd_data, mdl[0]);
        chk64("R7 ring_tx is top bit", {63'd0, ring_tx}, 64'd1);
        step(1'b1, 64'h0F0F_0000_FFFF_1234);
        mdl[0] = 64'h0F0F_0000_FFFF_1234;
        chk64("R2 back-to-back load", rd_data, mdl[0]);
        chk64("R3 ring_rx held on load", {63'd0, ring_rx}, {63'd0, rx0});
    endtask

    task automatic t_fill();
        for (int w = 0; w < NW; w++) begin
            logic [63:0] p;
            p = {32'hA500_0000 + 32'(w), ~(32'h1357_0000 + 32'(w * 7))};
            step(1'b1, p);
            mdl[0] = p;
            rotate_word();
            chk64("R5 word after 64 shifts", rd_data, mdl[0]);
            chk64("R7 ring_rx is last cell top bit", {63'd0, ring_rx},
                  {63'd0, mdl[NW-1][63]});
        end
    endtask

    task automatic t_single_shift();
        logic [63:0] h;
        logic [63:0] exp;
        logic        rx;
        h  = mdl[0];
        rx = mdl[NW-1][63];
        step(1'b0, '0);
        exp = {h[62:0], rx};
        chk64("R4 one-bit shift", rd_data, exp);
        chk64("R7 ring_tx after one shift", {63'd0, ring_tx}, {63'd0, h[62]});
        for (int i = 0; i < 63; i++) step(1'b0, '0);
        begin
            logic [63:0] t;
            t = mdl[NW-1];
            for (int k = NW - 1; k > 0; k--) mdl[k] = mdl[k-1];
            mdl[0] = t;
        end
        chk64("R5 realigned after 64 shifts", rd_data, mdl[0]);
    endtask

    task automatic t_full_lap();
        for (int k = 0; k < NW; k++) snap[k] = mdl[k];
        for (int w = 0; w < NW; w++) begin
            rotate_word();
            chk64("R6 word along lap", rd_data, mdl[0]);
        end
        for (int k = 0; k < NW; k++) chk64("R6 lap restores slot", mdl[k], snap[k]);
        chk64("R6 holding word after lap", rd_data, snap[0]);
    endtask

    task automatic t_edit_untouched();
        step(1'b1, 64'hDEAD_BEEF_0000_0001);
        mdl[0] = 64'hDEAD_BEEF_0000_0001;
        for (int w = 0; w < NW; w++) begin
            rotate_word();
            chk64("R3 untouched words after load", rd_data, mdl[0]);
        end
        chk64("R6 edited word back after lap", rd_data, 64'hDEAD_BEEF_0000_0001);
    endtask

    task automatic t_cell_count();
        do_reset();
        step(1'b1, 64'hC0DE_0000_0000_00C3);
        mdl[0] = 64'hC0DE_0000_0000_00C3;
        for (int w = 0; w < NC; w++) rotate_word();
        chk64("R8 holding word after cells*64", rd_data, '0);
        chk64("R8 marker in last cell top bit", {63'd0, ring_rx}, 64'd1);
        rotate_word();
        chk64("R8 marker back after one more word", rd_data, 64'hC0DE_0000_0000_00C3);
    endtask

    task automatic t_reset_mid();
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int i = 0; i < 5; i++) step(1'b0, '0);
        do_reset();
        chk64("R1 clear after mid reset", rd_data, '0);
        for (int w = 0; w < NW; w++) begin
            rotate_word();
            chk64("R1 lap zero after mid reset", rd_data, '0);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_load();
        t_fill();
        t_single_shift();
        t_full_lap();
        t_edit_untouched();
        t_cell_count();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule